// File: doc/BRIEF.md
# Sliding Ray Attack Generator

This block computes the attack set of a sliding piece on an 8x8 board held as a 64-bit bitboard, where square index = rank*8 + file. A request carries an occupancy word, a square operand and a piece selector. The block gathers the squares along all eight directions from the origin into the eight bytes of one word. Each byte is ordered outward from the origin. A set stop bit at the top of every byte keeps any borrow inside its own byte, so a single 64-bit subtraction followed by an XOR marks every square up to and including the first occupied one, on all selected rays at once. No lookup table is used. A per-square validity mask removes the stop bit and any positions past the board edge. The surviving bits are then scattered back to their board squares.

The work runs through a small controller with five named states. `ST_IDLE` waits for `start`. On an accepted start, the transition IDLE->PACK captures the operands. In `ST_PACK` the rays are gathered into the packed word and its mask, and the transition PACK->RESOLVE follows. In `ST_RESOLVE` the subtract-and-XOR is applied, and the transition RESOLVE->SCATTER follows. In `ST_SCATTER` the result is written back in board order, and the transition SCATTER->DONE follows. `ST_DONE` raises `done` for one cycle, and the transition DONE->IDLE follows. Every state except `ST_IDLE` holds the block busy.

Top module: `sliding_attack_gen`

## Requirements
- R1: The origin square is taken from bits [5:0] of `sq_i`. Bits [7:6] have no effect on the result.
- R2: With `piece_i` = 0 (rook), `attacks` holds the squares along the two file directions and the two rank directions. Each ray runs up to and including its first occupied square, or to the board edge.
- R3: With `piece_i` = 1 (bishop), `attacks` holds the squares along the four diagonal directions under the same first-blocker rule.
- R4: With `piece_i` = 2 (queen), `attacks` is the union of the rook and bishop sets for the same inputs.
- R5: With `piece_i` = 3, `attacks` is all zero.
- R6: The origin square is never set in `attacks`, whether or not it is occupied.
- R7: On an empty board a rook attacks exactly 14 squares from any origin.
- R8: `done` is high for exactly one cycle, and it comes 4 clock edges after the edge that accepts `start` while `busy` is low. `busy` is high from the edge after acceptance until the cycle after `done`. A `start` that arrives while `busy` is high is ignored.
- R9: After reset, `busy`, `done` and `attacks` are 0. `attacks` changes only in the cycle where `done` rises and holds until the next completion.
- R10: No ray wraps across a board edge. For example, a rook on square 7 attacks squares 0 to 6 and squares 15 to 63 of file 7, and never square 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when not busy |
| occ_i | input | 64 | Occupancy bitboard, bit = rank*8 + file |
| sq_i | input | 8 | Square operand, low 6 bits used |
| piece_i | input | 2 | 0 rook, 1 bishop, 2 queen, 3 none |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| attacks | output | 64 | Attack set of the last completed request |

## Verification
Hand-worked vectors cover several cases. Empty boards from corner squares show whether each ray direction reaches the full board edge and does not wrap. A sparse board with an occupied origin shows whether the first blocker is included and the squares behind it are cut off. A full board shows whether only the eight neighbours survive. Square operands with upper bits set and the null piece code show whether those fields are decoded as required. Random occupancies of varied density on all 64 squares, for all three piece types, are compared with a bench-side ray walker that steps square by square. This separates borrow-containment faults and mask faults from scatter-index faults. Directed sequences then probe the completion timing, starts issued while busy, and result hold.

// File: rtl/ray_attack_pkg.sv
package ray_attack_pkg;

    localparam int BOARD_SIDE = 8;
    localparam int BOARD_BITS = BOARD_SIDE * BOARD_SIDE;
    localparam int SQ_W       = $clog2(BOARD_BITS);
    localparam int N_DIR      = 8;
    localparam int LANE_W     = BOARD_SIDE;
    localparam int RAY_MAX    = BOARD_SIDE - 1;
    localparam int ORTHO_DIRS = N_DIR / 2;

    typedef enum logic [1:0] {
        PC_ROOK   = 2'd0,
        PC_BISHOP = 2'd1,
        PC_QUEEN  = 2'd2,
        PC_NONE   = 2'd3
    } piece_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PACK    = 3'd1,
        ST_RESOLVE = 3'd2,
        ST_SCATTER = 3'd3,
        ST_DONE    = 3'd4
    } gen_state_e;

    typedef struct packed {
        logic            ok;
        logic [SQ_W-1:0] idx;
    } ray_pos_t;

    // File step per direction lane (lane order is decoded by the resolver)
    function automatic int dir_df(int d);
        case (d)
            0: return 1;
            1: return -1;
            4: return 1;
            5: return -1;
            6: return -1;
            7: return 1;
            default: return 0;
        endcase
    endfunction

    // Rank step per direction lane
    function automatic int dir_dr(int d);
        case (d)
            2: return 1;
            3: return -1;
            4: return 1;
            5: return -1;
            6: return 1;
            7: return -1;
            default: return 0;
        endcase
    endfunction

    // Board square reached after s steps along lane d, with on-board flag
    function automatic ray_pos_t ray_pos(logic [SQ_W-1:0] sq, int d, int s);
        ray_pos_t p;
        int f;
        int r;
        int nf;
        int nr;
        f  = int'(sq) % BOARD_SIDE;
        r  = int'(sq) / BOARD_SIDE;
        nf = f + dir_df(d) * s;
        nr = r + dir_dr(d) * s;
        p.ok  = (nf >= 0) && (nf < BOARD_SIDE) && (nr >= 0) && (nr < BOARD_SIDE);
        p.idx = p.ok ? SQ_W'(nr * BOARD_SIDE + nf) : '0;
        return p;
    endfunction

    // Lanes below ORTHO_DIRS are file/rank rays, the rest diagonals
    function automatic logic lane_enable(piece_e pc, int d);
        case (pc)
            PC_ROOK:   return d < ORTHO_DIRS;
            PC_BISHOP: return d >= ORTHO_DIRS;
            PC_QUEEN:  return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ray_packer.sv
module ray_packer
    import ray_attack_pkg::*;
(
    input  logic [SQ_W-1:0]       sq,
    input  logic [BOARD_BITS-1:0] occ,
    output logic [BOARD_BITS-1:0] packed_x,
    output logic [BOARD_BITS-1:0] valid_mask
);

    for (genvar d = 0; d < N_DIR; d++) begin : g_lane
        for (genvar s = 1; s <= RAY_MAX; s++) begin : g_step
            ray_pos_t p;
            assign p = ray_pos(sq, d, s);
            assign packed_x[d*LANE_W + s - 1]   = p.ok & occ[p.idx];
            assign valid_mask[d*LANE_W + s - 1] = p.ok;
        end
        // Stop bit keeps borrows inside the lane
        assign packed_x[d*LANE_W + LANE_W - 1]   = 1'b1;
        assign valid_mask[d*LANE_W + LANE_W - 1] = 1'b0;
    end

endmodule

// File: rtl/ray_resolver.sv
module ray_resolver
    import ray_attack_pkg::*;
(
    input  logic [BOARD_BITS-1:0] packed_x,
    input  logic [BOARD_BITS-1:0] valid_mask,
    input  piece_e                piece,
    output logic [BOARD_BITS-1:0] reach
);

    logic [BOARD_BITS-1:0] unit_k;
    logic [BOARD_BITS-1:0] diff;

    for (genvar d = 0; d < N_DIR; d++) begin : g_k
        assign unit_k[d*LANE_W +: LANE_W] =
            lane_enable(piece, d) ? LANE_W'(1) : '0;
    end

    assign diff  = packed_x - unit_k;
    assign reach = (packed_x ^ diff) & valid_mask;

endmodule

// File: rtl/ray_scatter.sv
module ray_scatter
    import ray_attack_pkg::*;
(
    input  logic [SQ_W-1:0]       sq,
    input  logic [BOARD_BITS-1:0] reach,
    output logic [BOARD_BITS-1:0] board
);

    always_comb begin
        ray_pos_t p;
        board = '0;
        for (int d = 0; d < N_DIR; d++) begin
            for (int s = 1; s <= RAY_MAX; s++) begin
                p = ray_pos(sq, d, s);
                if (p.ok && reach[d*LANE_W + s - 1]) begin
                    board[p.idx] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sliding_attack_gen.sv
module sliding_attack_gen
    import ray_attack_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [BOARD_BITS-1:0] occ_i,
    input  logic [7:0]            sq_i,
    input  logic [1:0]            piece_i,
    output logic                  busy,
    output logic                  done,
    output logic [BOARD_BITS-1:0] attacks
);

    gen_state_e state_q, state_d;

    logic [BOARD_BITS-1:0] occ_q;
    logic [SQ_W-1:0]       sq_q;
    piece_e                piece_q;
    logic [BOARD_BITS-1:0] x_q, vmask_q, reach_q;
    logic [BOARD_BITS-1:0] x_c, vmask_c, reach_c, board_c;
    logic                  accept;
    logic                  unused_sq_hi;

    assign unused_sq_hi = ^sq_i[7:SQ_W];
    assign accept       = start && (state_q == ST_IDLE);

    ray_packer u_pack (
        .sq         (sq_q),
        .occ        (occ_q),
        .packed_x   (x_c),
        .valid_mask (vmask_c)
    );

    ray_resolver u_res (
        .packed_x   (x_q),
        .valid_mask (vmask_q),
        .piece      (piece_q),
        .reach      (reach_c)
    );

    ray_scatter u_scat (
        .sq    (sq_q),
        .reach (reach_q),
        .board (board_c)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_PACK;
            ST_PACK:    state_d = ST_RESOLVE;
            ST_RESOLVE: state_d = ST_SCATTER;
            ST_SCATTER: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_DONE);
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q   <= '0;
            sq_q    <= '0;
            piece_q <= PC_NONE;
            x_q     <= '0;
            vmask_q <= '0;
            reach_q <= '0;
            attacks <= '0;
        end else begin
            if (accept) begin
                occ_q   <= occ_i;
                sq_q    <= sq_i[SQ_W-1:0];
                piece_q <= piece_e'(piece_i);
            end
            if (state_q == ST_PACK) begin
                x_q     <= x_c;
                vmask_q <= vmask_c;
            end
            if (state_q == ST_RESOLVE) reach_q <= reach_c;
            if (state_q == ST_SCATTER) attacks <= board_c;
        end
    end

endmodule

// File: rtl/sliding_attack_gen_chk.sv
module sliding_attack_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [5:0]  sq_lo,
    input logic [1:0]  piece_i,
    input logic        busy,
    input logic        done,
    input logic [63:0] attacks
);

    logic       acc;
    logic [5:0] cap_sq;
    logic [1:0] cap_pc;

    assign acc = start && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_sq <= '0;
            cap_pc <= '0;
        end else if (acc) begin
            cap_sq <= sq_lo;
            cap_pc <= piece_i;
        end
    end

    p_done_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> ##3 done);

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> busy);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_origin_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !attacks[cap_sq]);

    p_null_piece_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_pc == 2'd3) |-> (attacks == 64'd0));

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(attacks) |-> done);

endmodule

bind sliding_attack_gen sliding_attack_gen_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .sq_lo   (sq_i[5:0]),
    .piece_i (piece_i),
    .busy    (busy),
    .done    (done),
    .attacks (attacks)
);

// File: tb/tb_sliding_attack_gen.sv
module tb_sliding_attack_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] occ_i = '0;
    logic [7:0]  sq_i = '0;
    logic [1:0]  piece_i = '0;
    logic        busy, done;
    logic [63:0] attacks;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    sliding_attack_gen dut (
        .clk(clk), .rst_n(rst_n), .start(start), .occ_i(occ_i),
        .sq_i(sq_i), .piece_i(piece_i), .busy(busy), .done(done),
        .attacks(attacks)
    );

    typedef struct packed {
        logic [63:0] occ;
        logic [7:0]  sq;
        logic [1:0]  pc;
        logic [63:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{64'h0, 8'd0,   2'd0, 64'h01010101010101FE, 4'd2},  // R2 corner rook
        '{64'h0, 8'd0,   2'd1, 64'h8040201008040200, 4'd3},  // R3 corner bishop
        '{64'h0, 8'd0,   2'd2, 64'h81412111090503FE, 4'd4},  // R4 corner queen
        '{64'h0, 8'd63,  2'd0, 64'h7F80808080808080, 4'd2},  // R2 far corner
        '{64'h0, 8'd7,   2'd0, 64'h808080808080807F, 4'd10}, // R10 no wrap
        '{64'h0000080068000000, 8'd27, 2'd0, 64'h0000080837080808, 4'd2}, // R2 blockers
        '{64'hFFFFFFFFFFFFFFFF, 8'd27, 2'd2, 64'h0000001C141C0000, 4'd6}, // R6 full board
        '{64'h0, 8'hC0,  2'd0, 64'h01010101010101FE, 4'd1},  // R1 upper bits
        '{64'h0, 8'hFF,  2'd1, 64'h0040201008040201, 4'd1},  // R1 upper bits
        '{64'h0, 8'd27,  2'd3, 64'h0,                4'd5}   // R5 null piece
    };

    function automatic logic [63:0] ref_attacks(logic [63:0] occ, int sq, int pc);
        logic [63:0] a = '0;
        int dfs [8] = '{1, -1, 0, 0, 1, -1, -1, 1};
        int drs [8] = '{0, 0, 1, -1, 1, -1, 1, -1};
        for (int d = 0; d < 8; d++) begin
            int f = sq % 8;
            int r = sq / 8;
            if (pc == 3) continue;
            if (pc == 0 && d >= 4) continue;
            if (pc == 1 && d < 4) continue;
            forever begin
                f += dfs[d];
                r += drs[d];
                if (f < 0 || f > 7 || r < 0 || r > 7) break;
                a[r*8+f] = 1'b1;
                if (occ[r*8+f]) break;
            end
        end
        return a;
    endfunction

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [63:0] occ, input logic [7:0] sq,
                          input logic [1:0] pc, output logic [63:0] res,
                          output int lat);
        @(negedge clk);
        occ_i = occ; sq_i = sq; piece_i = pc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        res = attacks;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] res, held;
        int lat;
        repeat (3) @(negedge clk);
        // R9 reset state
        check64("R9 reset attacks", attacks, 64'h0);
        check64("R9 reset busy/done", {62'h0, busy, done}, 64'h0);
        rst_n = 1'b1;

        foreach (VECS[i]) begin
            run_op(VECS[i].occ, VECS[i].sq, VECS[i].pc, res, lat);
            check64($sformatf("R%0d vector %0d", VECS[i].req, i), res, VECS[i].exp);
        end

        // R8 latency and one-cycle pulse
        run_op(64'h0, 8'd36, 2'd2, res, lat);
        check64("R8 latency", 64'(lat), 64'd4);
        @(negedge clk);
        check64("R8 pulse width", {63'h0, done}, 64'h0);

        // R8 start during busy is ignored
        @(negedge clk);
        occ_i = 64'h0; sq_i = 8'd0; piece_i = 2'd0; start = 1'b1;
        @(negedge clk);
        occ_i = 64'hFFFFFFFFFFFFFFFF; sq_i = 8'd45; piece_i = 2'd1;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check64("R8 done after busy start", {63'h0, done}, 64'h1);
        check64("R8 busy start ignored", attacks, ref_attacks(64'h0, 0, 0));
        @(negedge clk);
        check64("R8 busy clears", {62'h0, busy, done}, 64'h0);

        // R9 hold while idle with changing inputs
        held = attacks;
        occ_i = 64'h123456789ABCDEF0; sq_i = 8'd9; piece_i = 2'd2;
        repeat (6) @(negedge clk);
        check64("R9 hold", attacks, held);

        // R7 empty-board rook count on every square
        for (int s = 0; s < 64; s++) begin
            run_op(64'h0, 8'(s), 2'd0, res, lat);
            check64($sformatf("R7 rook count sq%0d", s), 64'($countones(res)), 64'd14);
        end

        // R2 R3 R4 R6 random occupancies, all squares and pieces
        for (int s = 0; s < 64; s++) begin
            for (int pc = 0; pc < 3; pc++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [63:0] occ;
                    occ = {$urandom(), $urandom()};
                    if (k == 0) occ &= {$urandom(), $urandom()};
                    if (k == 2) occ |= {$urandom(), $urandom()};
                    run_op(occ, 8'(s), 2'(pc), res, lat);
                    check64($sformatf("R%0d random sq%0d", pc + 2, s), res,
                            ref_attacks(occ, s, pc));
                    check64("R6 origin", {63'h0, res[s]}, 64'h0);
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule